// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a countdown watchdog that sits behind a small byte-addressed register port. Software programs a period in ticks, releases the halt bit and then writes the reload register often enough to keep the count from running out. The countdown only moves on cycles where an external prescaler asserts the tick-enable input, so the tick rate sets the real-time period.

If the count runs out once, the block flags a timeout in its status register and can raise an interrupt. If it runs out a second time without a reload in between, it records a second-timeout status and, unless the no-reboot lock is set, issues a one-cycle system reset request and records a boot status. Status bits are sticky and are cleared by writing ones to them.

Register map (16-bit registers, byte offsets): 0x00 control (bit0 halt, bit1 watchdog interrupt enable, bit2 global interrupt enable, bit3 no-reboot lock); 0x02 period (bits 9:0); 0x04 reload (write-only, any data); 0x06 status (bit0 first timeout, bit1 second timeout, bit2 boot); 0x08 current count (read-only). Reads return data one cycle after the read strobe.

Top module: `wdt_two_stage`

## Requirements
- R1: After reset the control register reads 0x0001 (halted, all enables and the lock clear), the period reads 613, the count reads 613, the status reads 0, and both the interrupt and reset request outputs are low.
- R2: The count does not change while control bit0 (halt) is set, and does not change on cycles where tick-enable is low.
- R3: A write of any data to offset 0x04 loads the count with the programmed period on the next clock, also while halted.
- R4: A write to offset 0x02 updates the period from data bits 9:0 only when that value lies in 2 to 613; otherwise the period keeps its old value. Bits 15:10 of the period register always read 0. A period write does not load the count.
- R5: The count decrements by one per enabled tick; the tick on which it would go below 1 is an expiry, which reloads the period, so expiries are exactly one period of ticks apart. The first expiry sets status bit0.
- R6: A second expiry with no reload since the first sets status bit1 and, when control bit3 is clear, sets status bit2 and drives the reset request high for exactly one cycle. After a second expiry the next expiry counts as a first one again.
- R7: A reload between expiries returns the block to the first stage, so the next expiry sets only status bit0.
- R8: While control bit3 (no-reboot) is set, a second expiry still sets status bit1 but neither pulses the reset request nor sets status bit2.
- R9: Writing a 1 to a status bit clears it; writing 0 leaves it unchanged.
- R10: The interrupt output is high exactly while status bit0, control bit1 and control bit2 are all set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | One-cycle enable from the prescaler; the count moves only when high |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Byte offset of the register |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, valid the cycle after rd_en |
| irq | output | 1 | Timeout interrupt (level) |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
The bench aims at the stage logic: a design that forgot to clear the stage on reload would reset the system after one missed reload following a serviced one, and one that never returned to the first stage after a reset request would pulse on every later expiry. It also checks that out-of-range period writes are dropped rather than truncated, that halt and a low tick both freeze the count, and that the no-reboot lock blocks the pulse yet still records the second timeout. Interrupt gating is probed with each enable alone, which catches a design that ORs the enables.

// File: rtl/wdt_pkg.sv
// Package: register offsets and field positions shared by the watchdog modules.
// Assumes 16-bit registers at even byte offsets.
package wdt_pkg;
    localparam logic [3:0] OFS_CTRL   = 4'h0;
    localparam logic [3:0] OFS_PERIOD = 4'h2;
    localparam logic [3:0] OFS_RELOAD = 4'h4;
    localparam logic [3:0] OFS_STATUS = 4'h6;
    localparam logic [3:0] OFS_COUNT  = 4'h8;

    localparam int CTRL_W       = 4;
    localparam int CTRL_HALT    = 0;
    localparam int CTRL_WDG_IE  = 1;
    localparam int CTRL_GLB_IE  = 2;
    localparam int CTRL_NO_RBT  = 3;

    localparam int STS_W        = 3;
    localparam int STS_FIRST    = 0;
    localparam int STS_SECOND   = 1;
    localparam int STS_BOOT     = 2;
endpackage

// File: rtl/wdt_regs.sv
// Register file: control, period, sticky status and read mux.
// Assumes event inputs are single-cycle pulses from the countdown module.
module wdt_regs #(
    parameter int DATA_W     = 16,
    parameter int ADDR_W     = 4,
    parameter int CNT_W      = 10,
    parameter int PERIOD_MIN = 2,
    parameter int PERIOD_MAX = 613
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              evt_first,
    input  logic              evt_second,
    input  logic              evt_boot,
    input  logic [CNT_W-1:0]  cnt,
    output logic              halt,
    output logic              no_reboot,
    output logic [CNT_W-1:0]  period,
    output logic              reload_stb,
    output logic              irq,
    output logic [DATA_W-1:0] rdata
);
    import wdt_pkg::*;

    logic [CTRL_W-1:0] ctrl_q;
    logic [STS_W-1:0]  sts_q;
    logic [STS_W-1:0]  sts_set;
    logic [STS_W-1:0]  sts_clr;
    logic [CNT_W-1:0]  wr_period_val;
    logic              wr_ctrl, wr_period, wr_sts, period_ok;
    logic              unused_wdata_hi;

    // Decode write strobes per register.
    always_comb begin
        wr_ctrl    = wr_en && (addr == ADDR_W'(OFS_CTRL));
        wr_period  = wr_en && (addr == ADDR_W'(OFS_PERIOD));
        wr_sts     = wr_en && (addr == ADDR_W'(OFS_STATUS));
        reload_stb = wr_en && (addr == ADDR_W'(OFS_RELOAD));
    end

    assign wr_period_val   = wdata[CNT_W-1:0];
    assign period_ok       = (wr_period_val >= CNT_W'(PERIOD_MIN)) &&
                             (wr_period_val <= CNT_W'(PERIOD_MAX));
    assign unused_wdata_hi = ^wdata[DATA_W-1:CNT_W];

    // Control register; comes up halted.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= CTRL_W'(1) << CTRL_HALT;
        else if (wr_ctrl) ctrl_q <= wdata[CTRL_W-1:0];
    end

    // Period register; out-of-range writes are dropped.
    always_ff @(posedge clk) begin
        if (!rst_n)                       period <= CNT_W'(PERIOD_MAX);
        else if (wr_period && period_ok)  period <= wr_period_val;
    end

    // Sticky status: hardware sets win over write-one-to-clear.
    always_comb begin
        sts_set              = '0;
        sts_set[STS_FIRST]   = evt_first;
        sts_set[STS_SECOND]  = evt_second;
        sts_set[STS_BOOT]    = evt_boot;
        sts_clr              = wr_sts ? wdata[STS_W-1:0] : '0;
    end

    // Status register update.
    always_ff @(posedge clk) begin
        if (!rst_n) sts_q <= '0;
        else        sts_q <= (sts_q & ~sts_clr) | sts_set;
    end

    // Registered read mux.
    always_ff @(posedge clk) begin
        if (!rst_n) rdata <= '0;
        else if (rd_en) begin
            case (addr)
                ADDR_W'(OFS_CTRL):   rdata <= DATA_W'(ctrl_q);
                ADDR_W'(OFS_PERIOD): rdata <= DATA_W'(period);
                ADDR_W'(OFS_STATUS): rdata <= DATA_W'(sts_q);
                ADDR_W'(OFS_COUNT):  rdata <= DATA_W'(cnt);
                default:             rdata <= '0;
            endcase
        end
    end

    assign halt      = ctrl_q[CTRL_HALT];
    assign no_reboot = ctrl_q[CTRL_NO_RBT];
    assign irq       = sts_q[STS_FIRST] & ctrl_q[CTRL_WDG_IE] & ctrl_q[CTRL_GLB_IE];

    AST_PERIOD_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (period >= CNT_W'(PERIOD_MIN)) && (period <= CNT_W'(PERIOD_MAX))); // R4
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sts && wdata[STS_FIRST] && !evt_first) |=> !sts_q[STS_FIRST]); // R9
    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_q[STS_SECOND] && !wr_sts) |=> sts_q[STS_SECOND]); // R6
endmodule

// File: rtl/wdt_counter.sv
// Countdown and two-stage expiry tracking.
// Assumes period is never below 2, so expiries are never back to back.
module wdt_counter #(
    parameter int CNT_W      = 10,
    parameter int PERIOD_MAX = 613
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             halt,
    input  logic             reload,
    input  logic             no_reboot,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] cnt,
    output logic             evt_first,
    output logic             evt_second,
    output logic             evt_boot,
    output logic             rst_req
);
    logic stage2_q;
    logic expire;

    // An expiry is an enabled tick arriving with the count at its floor.
    assign expire     = tick_en && !halt && !reload && (cnt <= CNT_W'(1));
    assign evt_first  = expire && !stage2_q;
    assign evt_second = expire && stage2_q;
    assign evt_boot   = evt_second && !no_reboot;

    // Count and stage state; reload has priority over ticking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= CNT_W'(PERIOD_MAX);
            stage2_q <= 1'b0;
        end else if (reload) begin
            cnt      <= period;
            stage2_q <= 1'b0;
        end else if (tick_en && !halt) begin
            if (expire) begin
                cnt      <= period;
                stage2_q <= !stage2_q;
            end else begin
                cnt      <= cnt - 1'b1;
            end
        end
    end

    // One-cycle reset request after an ungated second expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) rst_req <= 1'b0;
        else        rst_req <= evt_boot;
    end

    AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && !reload) |=> $stable(cnt)); // R2
    AST_RELOAD_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> (cnt == $past(period))); // R3
    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt >= CNT_W'(1)) && (cnt <= CNT_W'(PERIOD_MAX))); // R5
    AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req); // R6
    AST_NO_REBOOT_GATES: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> !$past(no_reboot)); // R8
endmodule

// File: rtl/wdt_two_stage.sv
// Top: two-stage watchdog with register port, interrupt and reset request.
// Assumes tick_en is a synchronous single-cycle enable from a prescaler.
module wdt_two_stage #(
    parameter int DATA_W     = 16,
    parameter int ADDR_W     = 4,
    parameter int CNT_W      = 10,
    parameter int PERIOD_MIN = 2,
    parameter int PERIOD_MAX = 613
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq,
    output logic              rst_req
);
    logic             halt, no_reboot, reload_stb;
    logic             evt_first, evt_second, evt_boot;
    logic [CNT_W-1:0] period, cnt;

    wdt_regs #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W),
        .PERIOD_MIN(PERIOD_MIN), .PERIOD_MAX(PERIOD_MAX)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata),
        .evt_first(evt_first), .evt_second(evt_second), .evt_boot(evt_boot),
        .cnt(cnt), .halt(halt), .no_reboot(no_reboot), .period(period),
        .reload_stb(reload_stb), .irq(irq), .rdata(rdata)
    );

    wdt_counter #(
        .CNT_W(CNT_W), .PERIOD_MAX(PERIOD_MAX)
    ) u_counter (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .halt(halt),
        .reload(reload_stb), .no_reboot(no_reboot), .period(period),
        .cnt(cnt), .evt_first(evt_first), .evt_second(evt_second),
        .evt_boot(evt_boot), .rst_req(rst_req)
    );
endmodule

// File: tb/wdt_two_stage_tb.sv
module wdt_two_stage_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        irq, rst_req;

    int errors = 0;
    int checks = 0;
    int pulses = 0;
    int wide_pulses = 0;
    logic prev_rst = 1'b0;
    logic [15:0] rd_val;

    // {write data, expected period readback}
    localparam logic [31:0] PERIOD_VEC [8] = '{
        {16'd100,   16'd100},
        {16'd1,     16'd100},
        {16'd614,   16'd100},
        {16'd2,     16'd2},
        {16'd613,   16'd613},
        {16'hFC05,  16'd5},
        {16'd0,     16'd5},
        {16'd5,     16'd5}
    };

    always #2 clk = ~clk;

    wdt_two_stage u_dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
        .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata),
        .irq(irq), .rst_req(rst_req)
    );

    // Reset-request pulse monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_req) pulses++;
        if (rst_req && prev_rst) wide_pulses++;
        prev_rst <= rst_req;
    end

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1 irq", {15'd0, irq}, 16'd0);
        check("R1 rst_req", {15'd0, rst_req}, 16'd0);
        rd(4'h0, rd_val); check("R1 ctrl", rd_val, 16'h0001);
        rd(4'h2, rd_val); check("R1 period", rd_val, 16'd613);
        rd(4'h8, rd_val); check("R1 count", rd_val, 16'd613);
        rd(4'h6, rd_val); check("R1 status", rd_val, 16'd0);

        // R4 period write vectors
        for (int i = 0; i < 8; i++) begin
            wr(4'h2, PERIOD_VEC[i][31:16]);
            rd(4'h2, rd_val);
            check("R4 period", rd_val, PERIOD_VEC[i][15:0]);
        end

        // R2 halt freezes; R4 period write did not load count
        ticks(10);
        rd(4'h8, rd_val); check("R2 halted count", rd_val, 16'd613);

        // R3 reload while halted, data ignored
        wr(4'h4, 16'hBEEF);
        rd(4'h8, rd_val); check("R3 reload count", rd_val, 16'd5);

        // R2 running but tick low
        wr(4'h0, 16'h0000);
        repeat (6) @(negedge clk);
        rd(4'h8, rd_val); check("R2 no tick count", rd_val, 16'd5);

        // R5 decrement and first expiry
        ticks(3);
        rd(4'h8, rd_val); check("R5 count after 3", rd_val, 16'd2);
        rd(4'h6, rd_val); check("R5 status before expiry", rd_val, 16'd0);
        ticks(2);
        rd(4'h6, rd_val); check("R5 first status", rd_val, 16'd1);
        rd(4'h8, rd_val); check("R5 count reloaded", rd_val, 16'd5);

        // R10 interrupt gating
        check("R10 irq no enables", {15'd0, irq}, 16'd0);
        wr(4'h0, 16'h0002); check("R10 irq wdog only", {15'd0, irq}, 16'd0);
        wr(4'h0, 16'h0004); check("R10 irq global only", {15'd0, irq}, 16'd0);
        wr(4'h0, 16'h0006); check("R10 irq both", {15'd0, irq}, 16'd1);

        // R6 second expiry
        ticks(5);
        repeat (2) @(negedge clk);
        rd(4'h6, rd_val); check("R6 status all", rd_val, 16'd7);
        check("R6 pulse count", 16'(pulses), 16'd1);
        check("R6 pulse width", 16'(wide_pulses), 16'd0);

        // R9 write-one-to-clear
        wr(4'h6, 16'h0002);
        rd(4'h6, rd_val); check("R9 clear bit1", rd_val, 16'd5);
        wr(4'h6, 16'h0005);
        rd(4'h6, rd_val); check("R9 clear rest", rd_val, 16'd0);
        check("R10 irq after clear", {15'd0, irq}, 16'd0);

        // R6 stage back to first; R7 reload restarts stage
        ticks(5);
        rd(4'h6, rd_val); check("R6 first after second", rd_val, 16'd1);
        wr(4'h4, 16'h0000);
        ticks(5);
        repeat (2) @(negedge clk);
        rd(4'h6, rd_val); check("R7 still first stage", rd_val, 16'd1);
        check("R7 no pulse", 16'(pulses), 16'd1);

        // R8 no-reboot lock
        wr(4'h6, 16'h0007);
        wr(4'h0, 16'h000E);
        wr(4'h4, 16'h1234);
        ticks(10);
        repeat (2) @(negedge clk);
        rd(4'h6, rd_val); check("R8 status", rd_val, 16'd3);
        check("R8 no pulse", 16'(pulses), 16'd1);

        finish_run();
    end
endmodule